// File: doc/BRIEF.md
# Load-linked / store-conditional reservation monitor

This block sits beside a small set-associative data cache. It records, for every resident line, which hardware context currently holds a load-linked reservation on it. When a store-conditional arrives, the block decides whether the store may go ahead. The block keeps the line tags itself, in flip-flops, so that it can find a request's line without help. Line data, the coherence protocol and the processor pipeline live elsewhere.

Requests arrive on a valid/ready port. Each carries an operation (load-linked, store-conditional, plain store or plain load), a line address and a context ID. A second port carries line events from the coherence controller:
- an install, which grants or re-grants permission for a line;
- an invalidation, which takes permission for a line away.

Every accepted request gets a registered response one cycle later. The response holds a success flag and a result word. The result word is zero whenever a store-conditional fails.

Top module: `llsc_monitor`

## Requirements
- R1: After reset every line is absent and unlocked (lock field all-ones), `rsp_valid` is low and `req_ready` is high, so every request then succeeds.
- R2: A load-linked (`req_op` = 0) that hits a resident line records the requesting context as that line's owner. The response is success.
- R3: A store-conditional (`req_op` = 1) that hits a resident line succeeds only when the line's owner equals `req_ctx`. Success gives `rsp_ok`=1 and `rsp_result`=1. Failure gives `rsp_ok`=0 and `rsp_result`=0. Only a store-conditional can fail.
- R4: Every store-conditional that hits a line leaves that line unlocked, whether it succeeded or failed.
- R5: A plain store (`req_op` = 2) that hits a line owned by the same context unlocks it. A plain store from another context leaves the owner unchanged. A plain store always succeeds.
- R6: A plain load (`req_op` = 3) changes no lock and always succeeds.
- R7: A request whose line is not resident succeeds and changes no lock.
- R8: An install (`ev_kind` = 0) always leaves its line resident and unlocked.
  - If the line is already resident, only its lock is reset.
  - Otherwise the line takes the lowest-numbered empty way of its set.
  - If the set is full, the line takes the way named by that set's round-robin pointer, and the pointer then advances. The evicted line loses its reservation.
  - The set is the low log2(SETS) bits of the address and the tag is the rest.
- R9: An invalidation (`ev_kind` = 1) of a resident line makes it absent and unlocked. A later install of that line finds it unlocked.
- R10: An invalidation and a request to the same line in the same cycle are resolved invalidation first. A store-conditional in that cycle fails, a load-linked in that cycle takes no reservation, and the line is absent afterwards.
- R11: `req_ready` is low exactly in cycles that carry an install event. An accepted request gets exactly one response cycle on the next clock edge. A request that is not accepted gets none.
- R12: Context ID all-ones never wins a store-conditional on a resident line, even after its own load-linked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | 0 load-linked, 1 store-conditional, 2 store, 3 load |
| req_addr | input | ADDR_W | Line address of the request |
| req_ctx | input | CTX_W | Requesting context ID |
| ev_valid | input | 1 | Line event present |
| ev_kind | input | 1 | 0 install / permission grant, 1 invalidation |
| ev_addr | input | ADDR_W | Line address of the event |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_ok | output | 1 | Success flag |
| rsp_result | output | RES_W | 1 on success, 0 on failure |

## Verification
The hardest case to reach from the ports is a reservation lost by side effect. One form is an invalidation that lands in the same cycle as a store-conditional to the same line. The other is a reserved line pushed out of a full set by the round-robin victim choice. The bench drives the event port and the request port together at one clock edge. It also sweeps two sets with four tags each, which is more tags than ways, so evictions happen often. Every step is compared against a way-level model in the bench, and an exhaustive sweep covers every owner, intervening operation and requester.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LL = 2'd0,
    OP_SC = 2'd1,
    OP_ST = 2'd2,
    OP_LD = 2'd3
  } llsc_op_e;

  typedef enum logic {
    EV_INSTALL = 1'b0,
    EV_INVAL   = 1'b1
  } llsc_ev_e;
endpackage

// File: rtl/llsc_tag_array.sv
module llsc_tag_array
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SETS   = 4,
  parameter int WAYS   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic                            ev_valid,
  input  llsc_ev_e                        ev_kind,
  input  logic [ADDR_W-1:0]               ev_addr,
  output logic                            req_hit,
  output logic [$clog2(SETS*WAYS)-1:0]    req_line,
  output logic                            ev_hit,
  output logic                            clr_en,
  output logic [$clog2(SETS*WAYS)-1:0]    clr_line
);
  localparam int SW    = $clog2(SETS);
  localparam int WW    = $clog2(WAYS);
  localparam int LINES = SETS * WAYS;
  localparam int LW    = $clog2(LINES);
  localparam int TW    = ADDR_W - SW;

  function automatic logic [SW-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[SW-1:0];
  endfunction

  function automatic logic [TW-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SW];
  endfunction

  function automatic logic [LW-1:0] line_of(input logic [SW-1:0] s, input logic [WW-1:0] w);
    return LW'(int'(s) * WAYS + int'(w));
  endfunction

  function automatic logic [WW-1:0] first_one(input logic [WAYS-1:0] v);
    logic [WW-1:0] r;
    r = '0;
    for (int k = WAYS - 1; k >= 0; k--) begin
      if (v[k]) r = WW'(k);
    end
    return r;
  endfunction

  function automatic logic [WW-1:0] next_rr(input logic [WW-1:0] r);
    return (int'(r) == WAYS - 1) ? '0 : r + WW'(1);
  endfunction

  logic [TW-1:0]   tag_q [LINES];
  logic [LINES-1:0] val_q;
  logic [WW-1:0]   rr_q  [SETS];

  logic [SW-1:0]   req_set, ev_set;
  logic [TW-1:0]   req_tag, ev_tag;
  logic [WAYS-1:0] req_hv, ev_hv, ev_free;
  logic [WW-1:0]   ev_way, inst_way, tgt_way;
  logic            ev_install, ev_inval, evicting;

  assign req_set    = set_of(req_addr);
  assign req_tag    = tag_of(req_addr);
  assign ev_set     = set_of(ev_addr);
  assign ev_tag     = tag_of(ev_addr);
  assign ev_install = ev_valid && (ev_kind == EV_INSTALL);
  assign ev_inval   = ev_valid && (ev_kind == EV_INVAL);

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      req_hv[w]  = val_q[line_of(req_set, WW'(w))] && (tag_q[line_of(req_set, WW'(w))] == req_tag);
      ev_hv[w]   = val_q[line_of(ev_set, WW'(w))] && (tag_q[line_of(ev_set, WW'(w))] == ev_tag);
      ev_free[w] = !val_q[line_of(ev_set, WW'(w))];
    end
  end

  assign req_hit  = |req_hv;
  assign req_line = line_of(req_set, first_one(req_hv));
  assign ev_hit   = |ev_hv;
  assign ev_way   = first_one(ev_hv);
  assign evicting = ev_install && !ev_hit && !(|ev_free);
  assign inst_way = ev_hit ? ev_way : ((|ev_free) ? first_one(ev_free) : rr_q[ev_set]);
  assign tgt_way  = ev_install ? inst_way : ev_way;
  assign clr_line = line_of(ev_set, tgt_way);
  assign clr_en   = ev_install || (ev_inval && ev_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      for (int l = 0; l < LINES; l++) tag_q[l] <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      if (ev_install) begin
        tag_q[clr_line] <= ev_tag;
        val_q[clr_line] <= 1'b1;
        if (evicting) rr_q[ev_set] <= next_rr(rr_q[ev_set]);
      end else if (ev_inval && ev_hit) begin
        val_q[clr_line] <= 1'b0;
      end
    end
  end

  AST_REQ_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_hv)); // R8
  AST_INSTALL_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_install |=> (val_q[$past(clr_line)] && tag_q[$past(clr_line)] == $past(ev_tag))); // R8
  AST_INVAL_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inval && ev_hit) |=> !val_q[$past(clr_line)]); // R9
endmodule

// File: rtl/llsc_lock_table.sv
module llsc_lock_table
  import llsc_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CTX_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc,
  input  llsc_op_e                  op,
  input  logic                      hit,
  input  logic [$clog2(LINES)-1:0]  line,
  input  logic [CTX_W-1:0]          ctx,
  input  logic                      clr_en,
  input  logic [$clog2(LINES)-1:0]  clr_line,
  output logic                      dec_ok
);
  localparam int LW = $clog2(LINES);
  localparam logic [CTX_W-1:0] UNL = '1;

  logic [CTX_W-1:0] lock_q [LINES];
  logic [LINES-1:0] hit_sel, clr_sel;
  logic             clash, owner_match;
  logic [CTX_W-1:0] eff_lock;

  assign clash       = clr_en && (clr_line == line);
  assign eff_lock    = clash ? UNL : lock_q[line];
  assign owner_match = (eff_lock == ctx) && (ctx != UNL);
  assign dec_ok      = !hit || (op != OP_SC) || owner_match;

  for (genvar i = 0; i < LINES; i++) begin : g_sel
    assign hit_sel[i] = acc && hit && (line == LW'(i));
    assign clr_sel[i] = clr_en && (clr_line == LW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) lock_q[i] <= UNL;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (clr_sel[i]) begin
          lock_q[i] <= UNL;
        end else if (hit_sel[i]) begin
          unique case (op)
            OP_LL:   lock_q[i] <= ctx;
            OP_SC:   lock_q[i] <= UNL;
            OP_ST:   if (lock_q[i] == ctx) lock_q[i] <= UNL;
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    AST_LL_TAKES_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_sel[i] && op == OP_LL && !clr_sel[i]) |=> (lock_q[i] == $past(ctx))); // R2
    AST_SC_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_sel[i] && op == OP_SC) |=> (lock_q[i] == UNL)); // R4
    AST_FOREIGN_STORE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_sel[i] && op == OP_ST && lock_q[i] != ctx && !clr_sel[i]) |=> $stable(lock_q[i])); // R5
    AST_EVENT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_sel[i] |=> (lock_q[i] == UNL)); // R9
  end
endmodule

// File: rtl/llsc_resp.sv
module llsc_resp
  import llsc_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             ok,
  input  llsc_op_e         op,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic [RES_W-1:0] rsp_result
);
  logic was_sc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_result <= '0;
      was_sc     <= 1'b0;
    end else begin
      rsp_valid <= acc;
      if (acc) begin
        rsp_ok     <= ok;
        rsp_result <= ok ? RES_W'(1) : '0;
        was_sc     <= (op == OP_SC);
      end
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R11
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid); // R11
  AST_FAIL_ONLY_SC: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> was_sc); // R3
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int CTX_W  = 2,
  parameter int RES_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic              ev_valid,
  input  logic              ev_kind,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [RES_W-1:0]  rsp_result
);
  localparam int LINES = SETS * WAYS;
  localparam int LW    = $clog2(LINES);

  llsc_op_e          op;
  llsc_ev_e          evk;
  logic              acc, req_hit, ev_hit, clr_en, dec_ok;
  logic              ev_install, ev_inval;
  logic [LW-1:0]     req_line, clr_line;

  assign op         = llsc_op_e'(req_op);
  assign evk        = llsc_ev_e'(ev_kind);
  assign ev_install = ev_valid && (evk == EV_INSTALL);
  assign ev_inval   = ev_valid && (evk == EV_INVAL);
  assign req_ready  = !ev_install;
  assign acc        = req_valid && req_ready;

  llsc_tag_array #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_tags (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .ev_valid(ev_valid),
    .ev_kind(evk), .ev_addr(ev_addr), .req_hit(req_hit), .req_line(req_line),
    .ev_hit(ev_hit), .clr_en(clr_en), .clr_line(clr_line)
  );

  llsc_lock_table #(.LINES(LINES), .CTX_W(CTX_W)) u_locks (
    .clk(clk), .rst_n(rst_n), .acc(acc), .op(op), .hit(req_hit),
    .line(req_line), .ctx(req_ctx), .clr_en(clr_en), .clr_line(clr_line),
    .dec_ok(dec_ok)
  );

  llsc_resp #(.RES_W(RES_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .acc(acc), .ok(dec_ok), .op(op),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_result(rsp_result)
  );

  AST_MISS_SUCCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_hit) |=> rsp_ok); // R7
  AST_SAME_CYCLE_INVAL_FAILS_SC: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_SC && ev_inval && ev_hit && ev_addr == req_addr) |=> !rsp_ok); // R10
  AST_ALLONES_CTX_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_SC && req_hit && (&req_ctx)) |=> !rsp_ok); // R12
  AST_NO_ACCEPT_DURING_INSTALL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_install) |=> !rsp_valid); // R11
endmodule

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'd0;
  logic [5:0] req_addr = 6'd0;
  logic [1:0] req_ctx = 2'd0;
  logic       ev_valid = 1'b0;
  logic       ev_kind = 1'b0;
  logic [5:0] ev_addr = 6'd0;
  logic       rsp_valid;
  logic       rsp_ok;
  logic [7:0] rsp_result;

  int tests = 0;
  int fails = 0;

  // model of a 4-set, 2-way array; lock 3 means unlocked
  int mtag  [4][2];
  bit mval  [4][2];
  int mlock [4][2];
  int mrr   [4];

  always #4 clk = ~clk;

  llsc_monitor u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_ctx(req_ctx),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_result(rsp_result)
  );

  task automatic chk(input bit good, input string req, input string what, input int act, input int exp);
    tests++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mfind(input int a);
    int s = a % 4;
    int t = a / 4;
    for (int w = 0; w < 2; w++) if (mval[s][w] && mtag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic m_install(input int a);
    int s = a % 4;
    int w = mfind(a);
    if (w < 0) begin
      if (!mval[s][0]) w = 0;
      else if (!mval[s][1]) w = 1;
      else begin w = mrr[s]; mrr[s] = (mrr[s] + 1) % 2; end
      mtag[s][w] = a / 4;
      mval[s][w] = 1'b1;
    end
    mlock[s][w] = 3;
  endtask

  task automatic m_inval(input int a);
    int w = mfind(a);
    if (w >= 0) begin mval[a % 4][w] = 1'b0; mlock[a % 4][w] = 3; end
  endtask

  task automatic do_install(input int a);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 1'b0; ev_addr = 6'(a);
    m_install(a);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic do_inval(input int a);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 1'b1; ev_addr = 6'(a);
    m_inval(a);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  // op: 0 LL, 1 SC, 2 store, 3 load; inv drives an invalidation of the same line in the same cycle
  task automatic do_op(input int o, input int a, input int c, input bit inv, input string req);
    int  s = a % 4;
    int  w = mfind(a);
    bit  hit = (w >= 0);
    int  eff = hit ? mlock[s][w] : 3;
    bit  exp;
    if (inv) begin m_inval(a); eff = 3; end
    exp = !hit || (o != 1) || (eff == c && c != 3);
    if (hit && !inv) begin
      case (o)
        0: mlock[s][w] = c;
        1: mlock[s][w] = 3;
        2: if (mlock[s][w] == c) mlock[s][w] = 3;
        default: ;
      endcase
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(o); req_addr = 6'(a); req_ctx = 2'(c);
    if (inv) begin ev_valid = 1'b1; ev_kind = 1'b1; ev_addr = 6'(a); end
    @(negedge clk);
    chk(rsp_valid && rsp_ok == exp && rsp_result == (exp ? 8'd1 : 8'd0), req,
        $sformatf("op%0d addr%0d ctx%0d ok/result", o, a, c), int'(rsp_ok) * 256 + int'(rsp_result),
        int'(exp) * 257);
    req_valid = 1'b0;
    ev_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", "cycles", 100000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int s = 0; s < 4; s++) begin
      mrr[s] = 0;
      for (int w = 0; w < 2; w++) begin mtag[s][w] = 0; mval[s][w] = 1'b0; mlock[s][w] = 3; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    for (int a = 0; a < 64; a++) do_op(1, a, 0, 1'b0, "R1");

    // owner, foreign and repeated store-conditional on line 0 (set 0, tag 0)
    do_install(0);
    do_op(0, 0, 1, 1'b0, "R2");
    do_op(1, 0, 2, 1'b0, "R3");
    do_op(1, 0, 1, 1'b0, "R4");
    do_op(0, 0, 1, 1'b0, "R2");
    do_op(1, 0, 1, 1'b0, "R3");
    do_op(1, 0, 1, 1'b0, "R4");
    // plain stores
    do_op(0, 0, 1, 1'b0, "R2");
    do_op(2, 0, 2, 1'b0, "R5");
    do_op(1, 0, 1, 1'b0, "R5");
    do_op(0, 0, 1, 1'b0, "R2");
    do_op(2, 0, 1, 1'b0, "R5");
    do_op(1, 0, 1, 1'b0, "R5");
    // plain load
    do_op(0, 0, 1, 1'b0, "R2");
    do_op(3, 0, 1, 1'b0, "R6");
    do_op(1, 0, 1, 1'b0, "R6");
    // permission re-grant resets the lock
    do_op(0, 0, 1, 1'b0, "R2");
    do_install(0);
    do_op(1, 0, 1, 1'b0, "R8");
    // replacement: fill set 0, then evict way 0 (address 0)
    do_install(4);
    do_op(0, 0, 0, 1'b0, "R2");
    do_op(0, 4, 1, 1'b0, "R2");
    do_install(8);
    do_op(1, 0, 0, 1'b0, "R8");
    do_op(1, 4, 1, 1'b0, "R8");
    do_op(1, 12, 2, 1'b0, "R7");
    // invalidation
    do_op(0, 8, 2, 1'b0, "R2");
    do_inval(8);
    do_op(1, 8, 2, 1'b0, "R9");
    do_install(8);
    do_op(1, 8, 2, 1'b0, "R9");
    // same-cycle invalidation and request
    do_install(1);
    do_op(0, 1, 1, 1'b0, "R2");
    do_op(1, 1, 1, 1'b1, "R10");
    do_op(1, 1, 1, 1'b0, "R10");
    do_install(1);
    do_op(0, 1, 1, 1'b1, "R10");
    do_install(1);
    do_op(1, 1, 1, 1'b0, "R10");
    // handshake
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 1'b0; ev_addr = 6'd2;
    req_valid = 1'b1; req_op = 2'd0; req_addr = 6'd2; req_ctx = 2'd0;
    m_install(2);
    #1;
    chk(req_ready == 1'b0, "R11", "req_ready during install", int'(req_ready), 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid after refused request", int'(rsp_valid), 0);
    req_valid = 1'b0; ev_valid = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R11", "req_ready without install", int'(req_ready), 1);
    do_op(1, 2, 0, 1'b0, "R11");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", "single response cycle", int'(rsp_valid), 0);
    // context all-ones
    do_op(0, 2, 3, 1'b0, "R12");
    do_op(1, 2, 3, 1'b0, "R12");

    // exhaustive: owner a, intervening op by b, then SC by a
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int o = 0; o < 4; o++) begin
          do_install(6);
          do_op(0, 6, a, 1'b0, "R2");
          do_op(o, 6, b, 1'b0, (o == 1) ? "R3" : (o == 2) ? "R5" : (o == 3) ? "R6" : "R2");
          do_op(1, 6, a, 1'b0, "R4");
        end

    // pseudo-random mix over two sets with four tags each
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      int a, k, o, c;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      k = int'(lfsr[3:0]);
      a = int'(lfsr[5:4]) * 4 + int'(lfsr[6]);
      c = int'(lfsr[8:7]);
      o = int'(lfsr[10:9]);
      if (k < 3) do_install(a);
      else if (k == 3) do_inval(a);
      else if (k == 4) do_op(o, a, c, 1'b1, "R10");
      else do_op(o, a, c, 1'b0, (o == 0) ? "R2" : (o == 1) ? "R3" : (o == 2) ? "R5" : "R6");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule